// File: doc/BRIEF.md
# Dual-Pipe Register Scoreboard Stall Unit

This block decides, cycle by cycle, whether the instructions of a two-pipe processor may enter their next stage, given the registers that older instructions are still producing. Pipe 0 is the integer pipe and pipe 1 is the floating-point pipe. An instruction that is about to move from decode into the register-access stage presents its source, destination and reservation lengths. The block checks them against a per-register scoreboard. When the instruction advances, the block records how long its destination stays unavailable. It keeps two lengths for that destination: one that integer-pipe readers see and one that floating-point readers see.

A second, later check point sits in front of the first execute stage. It serves operands that are read late, such as the data register of a store, and it stalls only the pipe that asks. The register-access stall is a single signal shared by both pipes, so a dual-issued pair either moves together or waits together. The caller raises the valid bit of a check point only when the stage behind it is empty. Decoding the instruction into register fields and latencies is done outside this block.

Top module: `scb_stall_unit`

## Requirements
- R1: After reset every register is free: no source, destination or late read causes a stall until a writer advances.
- R2: A pipe-0 reader presented in the cycle after a writer advances stalls for exactly the writer's integer-reader count, in cycles.
- R3: A pipe-1 reader presented in the cycle after a writer advances stalls for exactly the writer's floating-point-reader count, which is independent of the integer count.
- R4: A reservation count of zero reserves nothing for that reader class.
- R5: Each reservation counts down by one per cycle, so a reader presented g cycles after the cycle following the writer's advance stalls for count minus g cycles (never below zero).
- R6: A double-width destination reserves both rd and rd+1. When rd is 63, the second register does not exist and no other register (in particular r0) is reserved.
- R7: A double-width source reads both rs and rs+1 and stalls if either one is busy for the reader's class.
- R8: A writer whose destination is still reserved under either class count stalls at the register-access check until both counts reach zero (write-after-write).
- R9: The late check before the first execute stage stalls only its own pipe, uses that pipe's reader class, honours double width, and never raises the register-access stall.
- R10: One register-access stall is shared by both pipes. A stalled writer reserves nothing until the cycle in which it actually advances.
- R11: Register fields are ignored when their valid bits are low: an empty check point, or a source with its valid bit clear, never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ra_vld | input | 2 | Per pipe: an instruction is waiting at the register-access check and the stage behind it is empty |
| ra_src_vld | input | 2x3 | Per pipe, per source slot: the slot reads a register |
| ra_src_idx | input | 2x3x6 | Per pipe, per source slot: register index |
| ra_src_dbl | input | 2x3 | Per pipe, per source slot: double-width read (index and index+1) |
| ra_dst_vld | input | 2 | Per pipe: the instruction writes a register |
| ra_dst_idx | input | 2x6 | Per pipe: destination index |
| ra_dst_dbl | input | 2 | Per pipe: double-width destination |
| ra_lat_int | input | 2x4 | Per pipe: cycles the destination stays busy for integer-pipe readers |
| ra_lat_fp | input | 2x4 | Per pipe: cycles the destination stays busy for floating-point-pipe readers |
| e1_vld | input | 2 | Per pipe: an instruction waiting before the first execute stage reads a late operand |
| e1_idx | input | 2x6 | Per pipe: late operand index |
| e1_dbl | input | 2 | Per pipe: late operand is double width |
| ra_stall | output | 1 | Shared register-access stall for both pipes |
| e1_stall | output | 2 | Per-pipe stall before the first execute stage |

## Verification
The assertions assume that a dual-issued pair never names the same destination register in both pipes, because the pair would then have a write dependency that the issue logic outside this block rules out. The bench keeps within this by giving every writer in a pair its own register and issuing paired writers only on different indices. It also waits for the counters to drain between scenarios, so that each measured stall length depends only on that scenario's writers.

// File: rtl/scb_pkg.sv
package scb_pkg;

    localparam int NUM_PIPES = 2;

    typedef enum int {
        PIPE_INT = 0,
        PIPE_FP  = 1
    } pipe_e;

endpackage

// File: rtl/scb_reg_decode.sv
// Expands a register reference into a one-hot (or two-hot) mask over the file.
module scb_reg_decode #(
    parameter int NREG = 64,
    parameter int RW   = $clog2(NREG)
) (
    input  logic            en,
    input  logic [RW-1:0]   idx,
    input  logic            dbl,
    output logic [NREG-1:0] mask
);

    localparam logic [RW-1:0] LAST_IDX = RW'(NREG - 1);

    logic [RW-1:0] idx_next;
    logic          has_pair;

    always_comb begin
        idx_next = idx + RW'(1);
        has_pair = dbl && (idx != LAST_IDX);
        mask     = '0;
        if (en) begin
            mask[idx] = 1'b1;
            if (has_pair) begin
                mask[idx_next] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/scb_counters.sv
// Per-register reservation counters, one per reader class.
module scb_counters #(
    parameter int NREG = 64,
    parameter int CW   = 4,
    parameter int NP   = scb_pkg::NUM_PIPES
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NP-1:0]            ld_vld,
    input  logic [NP-1:0][NREG-1:0]  ld_mask,
    input  logic [NP-1:0][CW-1:0]    ld_lat_int,
    input  logic [NP-1:0][CW-1:0]    ld_lat_fp,
    output logic [NREG-1:0]          busy_int,
    output logic [NREG-1:0]          busy_fp
);

    typedef struct packed {
        logic [NREG-1:0][CW-1:0] cnt_int;
        logic [NREG-1:0][CW-1:0] cnt_fp;
    } cnt_state_t;

    cnt_state_t state_d;
    cnt_state_t state_q;

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NREG; i++) begin
            if (state_q.cnt_int[i] != '0) begin
                state_d.cnt_int[i] = state_q.cnt_int[i] - CW'(1);
            end
            if (state_q.cnt_fp[i] != '0) begin
                state_d.cnt_fp[i] = state_q.cnt_fp[i] - CW'(1);
            end
        end
        // Higher pipe index wins if both load one register (excluded by issue rules).
        for (int p = 0; p < NP; p++) begin
            for (int i = 0; i < NREG; i++) begin
                if (ld_vld[p] && ld_mask[p][i]) begin
                    state_d.cnt_int[i] = ld_lat_int[p];
                    state_d.cnt_fp[i]  = ld_lat_fp[p];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_busy
        assign busy_int[g] = (state_q.cnt_int[g] != '0);
        assign busy_fp[g]  = (state_q.cnt_fp[g]  != '0);
    end

endmodule

// File: rtl/scb_hazard.sv
// Hazard lookup for one pipe: early sources, destination and late operand.
module scb_hazard #(
    parameter int NREG = 64,
    parameter int NSRC = 3,
    parameter int RW   = $clog2(NREG)
) (
    input  logic [NREG-1:0]           busy_cls,
    input  logic [NREG-1:0]           busy_any,
    input  logic [NSRC-1:0]           src_vld,
    input  logic [NSRC-1:0][RW-1:0]   src_idx,
    input  logic [NSRC-1:0]           src_dbl,
    input  logic                      dst_vld,
    input  logic [RW-1:0]             dst_idx,
    input  logic                      dst_dbl,
    input  logic                      late_vld,
    input  logic [RW-1:0]             late_idx,
    input  logic                      late_dbl,
    output logic                      raw_hz,
    output logic                      waw_hz,
    output logic                      late_hz,
    output logic [NREG-1:0]           dst_mask
);

    logic [NSRC-1:0][NREG-1:0] src_mask;
    logic [NREG-1:0]           src_union;
    logic [NREG-1:0]           late_mask;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        scb_reg_decode #(.NREG(NREG), .RW(RW)) u_src_dec (
            .en   (src_vld[s]),
            .idx  (src_idx[s]),
            .dbl  (src_dbl[s]),
            .mask (src_mask[s])
        );
    end

    scb_reg_decode #(.NREG(NREG), .RW(RW)) u_dst_dec (
        .en   (dst_vld),
        .idx  (dst_idx),
        .dbl  (dst_dbl),
        .mask (dst_mask)
    );

    scb_reg_decode #(.NREG(NREG), .RW(RW)) u_late_dec (
        .en   (late_vld),
        .idx  (late_idx),
        .dbl  (late_dbl),
        .mask (late_mask)
    );

    always_comb begin
        src_union = '0;
        for (int s = 0; s < NSRC; s++) begin
            src_union = src_union | src_mask[s];
        end
        raw_hz  = |(src_union & busy_cls);
        waw_hz  = |(dst_mask  & busy_any);
        late_hz = |(late_mask & busy_cls);
    end

endmodule

// File: rtl/scb_stall_unit.sv
// Register scoreboard stall unit for an integer pipe and a floating-point pipe.
module scb_stall_unit #(
    parameter int NREG = 64,
    parameter int NSRC = 3,
    parameter int CW   = 4,
    parameter int RW   = $clog2(NREG)
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic [scb_pkg::NUM_PIPES-1:0]               ra_vld,
    input  logic [scb_pkg::NUM_PIPES-1:0][NSRC-1:0]     ra_src_vld,
    input  logic [scb_pkg::NUM_PIPES-1:0][NSRC-1:0][RW-1:0] ra_src_idx,
    input  logic [scb_pkg::NUM_PIPES-1:0][NSRC-1:0]     ra_src_dbl,
    input  logic [scb_pkg::NUM_PIPES-1:0]               ra_dst_vld,
    input  logic [scb_pkg::NUM_PIPES-1:0][RW-1:0]       ra_dst_idx,
    input  logic [scb_pkg::NUM_PIPES-1:0]               ra_dst_dbl,
    input  logic [scb_pkg::NUM_PIPES-1:0][CW-1:0]       ra_lat_int,
    input  logic [scb_pkg::NUM_PIPES-1:0][CW-1:0]       ra_lat_fp,
    input  logic [scb_pkg::NUM_PIPES-1:0]               e1_vld,
    input  logic [scb_pkg::NUM_PIPES-1:0][RW-1:0]       e1_idx,
    input  logic [scb_pkg::NUM_PIPES-1:0]               e1_dbl,
    output logic                                        ra_stall,
    output logic [scb_pkg::NUM_PIPES-1:0]               e1_stall
);

    import scb_pkg::*;

    localparam int NP = NUM_PIPES;

    logic [NREG-1:0]          busy_int;
    logic [NREG-1:0]          busy_fp;
    logic [NREG-1:0]          busy_any;
    logic [NP-1:0][NREG-1:0]  cls_busy;
    logic [NP-1:0][NREG-1:0]  dst_mask;
    logic [NP-1:0]            raw_hz;
    logic [NP-1:0]            waw_hz;
    logic [NP-1:0]            late_hz;
    logic [NP-1:0]            pipe_hz;
    logic [NP-1:0]            ld_vld;

    assign busy_any = busy_int | busy_fp;

    for (genvar p = 0; p < NP; p++) begin : g_pipe
        if (p == int'(PIPE_INT)) begin : g_int_cls
            assign cls_busy[p] = busy_int;
        end else begin : g_fp_cls
            assign cls_busy[p] = busy_fp;
        end

        scb_hazard #(.NREG(NREG), .NSRC(NSRC), .RW(RW)) u_hazard (
            .busy_cls (cls_busy[p]),
            .busy_any (busy_any),
            .src_vld  (ra_src_vld[p]),
            .src_idx  (ra_src_idx[p]),
            .src_dbl  (ra_src_dbl[p]),
            .dst_vld  (ra_dst_vld[p]),
            .dst_idx  (ra_dst_idx[p]),
            .dst_dbl  (ra_dst_dbl[p]),
            .late_vld (e1_vld[p]),
            .late_idx (e1_idx[p]),
            .late_dbl (e1_dbl[p]),
            .raw_hz   (raw_hz[p]),
            .waw_hz   (waw_hz[p]),
            .late_hz  (late_hz[p]),
            .dst_mask (dst_mask[p])
        );
    end

    always_comb begin
        for (int p = 0; p < NP; p++) begin
            pipe_hz[p] = ra_vld[p] & (raw_hz[p] | waw_hz[p]);
        end
        ra_stall = |pipe_hz;
        for (int p = 0; p < NP; p++) begin
            ld_vld[p]   = ra_vld[p] & ~ra_stall & ra_dst_vld[p];
            e1_stall[p] = late_hz[p];
        end
    end

    scb_counters #(.NREG(NREG), .CW(CW), .NP(NP)) u_counters (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_vld     (ld_vld),
        .ld_mask    (dst_mask),
        .ld_lat_int (ra_lat_int),
        .ld_lat_fp  (ra_lat_fp),
        .busy_int   (busy_int),
        .busy_fp    (busy_fp)
    );

endmodule

// File: rtl/scb_stall_checker.sv
module scb_stall_checker #(
    parameter int NREG = 64,
    parameter int CW   = 4,
    parameter int RW   = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           ra_vld,
    input  logic [1:0]           ra_dst_vld,
    input  logic [1:0][RW-1:0]   ra_dst_idx,
    input  logic [1:0][CW-1:0]   ra_lat_int,
    input  logic [1:0][CW-1:0]   ra_lat_fp,
    input  logic [1:0]           e1_vld,
    input  logic                 ra_stall,
    input  logic [1:0]           e1_stall,
    input  logic [NREG-1:0]      busy_int,
    input  logic [NREG-1:0]      busy_fp
);

    logic [NREG-1:0] busy_all;
    assign busy_all = busy_int | busy_fp;

    // R11: an empty check point never stalls
    p_idle_no_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_vld == 2'b00) |-> !ra_stall);

    // R9: late check is silent when its pipe asks nothing
    p_e1_quiet_pipe0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !e1_vld[0] |-> !e1_stall[0]);
    p_e1_quiet_pipe1_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !e1_vld[1] |-> !e1_stall[1]);

    // R2: an advancing writer with a nonzero integer count reserves its destination
    p_reserve_int_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_vld[0] && !ra_stall && ra_dst_vld[0] && ra_lat_int[0] != '0)
        |=> busy_int[$past(ra_dst_idx[0])]);

    // R3: same for the floating-point reader class on pipe 1
    p_reserve_fp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_vld[1] && !ra_stall && ra_dst_vld[1] && ra_lat_fp[1] != '0)
        |=> busy_fp[$past(ra_dst_idx[1])]);

    // R10: without an advancing writer no register becomes newly busy
    p_no_load_when_stalled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_stall || !((ra_vld[0] && ra_dst_vld[0]) || (ra_vld[1] && ra_dst_vld[1])))
        |=> ((busy_all & ~$past(busy_all)) == '0));

    // R10: input assumption, a dual-issued pair never shares a destination
    p_pair_distinct_dest_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_vld == 2'b11 && ra_dst_vld == 2'b11) |-> (ra_dst_idx[0] != ra_dst_idx[1]));

endmodule

bind scb_stall_unit scb_stall_checker #(.NREG(NREG), .CW(CW), .RW(RW)) u_scb_stall_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ra_vld     (ra_vld),
    .ra_dst_vld (ra_dst_vld),
    .ra_dst_idx (ra_dst_idx),
    .ra_lat_int (ra_lat_int),
    .ra_lat_fp  (ra_lat_fp),
    .e1_vld     (e1_vld),
    .ra_stall   (ra_stall),
    .e1_stall   (e1_stall),
    .busy_int   (busy_int),
    .busy_fp    (busy_fp)
);

// File: tb/scb_stall_unit_bench.sv
`timescale 1ns/1ps
module scb_stall_unit_bench;

    localparam int NREG = 64;
    localparam int NSRC = 3;
    localparam int CW   = 4;
    localparam int RW   = 6;

    logic                        clk = 1'b0;
    logic                        rst_n = 1'b0;
    logic [1:0]                  ra_vld;
    logic [1:0][NSRC-1:0]        ra_src_vld;
    logic [1:0][NSRC-1:0][RW-1:0] ra_src_idx;
    logic [1:0][NSRC-1:0]        ra_src_dbl;
    logic [1:0]                  ra_dst_vld;
    logic [1:0][RW-1:0]          ra_dst_idx;
    logic [1:0]                  ra_dst_dbl;
    logic [1:0][CW-1:0]          ra_lat_int;
    logic [1:0][CW-1:0]          ra_lat_fp;
    logic [1:0]                  e1_vld;
    logic [1:0][RW-1:0]          e1_idx;
    logic [1:0]                  e1_dbl;
    logic                        ra_stall;
    logic [1:0]                  e1_stall;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    scb_stall_unit #(.NREG(NREG), .NSRC(NSRC), .CW(CW), .RW(RW)) u_scb_stall_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .ra_vld     (ra_vld),
        .ra_src_vld (ra_src_vld),
        .ra_src_idx (ra_src_idx),
        .ra_src_dbl (ra_src_dbl),
        .ra_dst_vld (ra_dst_vld),
        .ra_dst_idx (ra_dst_idx),
        .ra_dst_dbl (ra_dst_dbl),
        .ra_lat_int (ra_lat_int),
        .ra_lat_fp  (ra_lat_fp),
        .e1_vld     (e1_vld),
        .e1_idx     (e1_idx),
        .e1_dbl     (e1_dbl),
        .ra_stall   (ra_stall),
        .e1_stall   (e1_stall)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_all();
        ra_vld = '0; ra_src_vld = '0; ra_src_idx = '0; ra_src_dbl = '0;
        ra_dst_vld = '0; ra_dst_idx = '0; ra_dst_dbl = '0;
        ra_lat_int = '0; ra_lat_fp = '0;
        e1_vld = '0; e1_idx = '0; e1_dbl = '0;
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            clear_all();
        end
    endtask

    // One-cycle writer presentation; assumes it is not stalled.
    task automatic put_writer(int p, int d, bit dbl, int li, int lf);
        @(negedge clk);
        clear_all();
        ra_vld[p] = 1'b1; ra_dst_vld[p] = 1'b1;
        ra_dst_idx[p] = RW'(d); ra_dst_dbl[p] = dbl;
        ra_lat_int[p] = CW'(li); ra_lat_fp[p] = CW'(lf);
    endtask

    // Presents one instruction and counts the cycles it is held at the check.
    task automatic measure(int p, bit s_en, int s, bit sdbl, bit d_en, int d,
                           int li, output int n);
        @(negedge clk);
        clear_all();
        ra_vld[p] = 1'b1;
        ra_src_vld[p][0] = s_en; ra_src_idx[p][0] = RW'(s); ra_src_dbl[p][0] = sdbl;
        ra_dst_vld[p] = d_en; ra_dst_idx[p] = RW'(d); ra_lat_int[p] = CW'(li);
        #1;
        n = 0;
        while (ra_stall && n < 40) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic t_reset();
        int n;
        check("R1 ra_stall in reset", int'(ra_stall), 0);
        for (int p = 0; p < 2; p++) begin
            @(negedge clk);
            clear_all();
            ra_vld[p] = 1'b1; ra_src_vld[p] = '1;
            ra_src_idx[p][0] = 6'd5; ra_src_idx[p][1] = 6'd6;
            ra_src_idx[p][2] = 6'd63; ra_src_dbl[p][2] = 1'b1;
            ra_dst_vld[p] = 1'b1; ra_dst_idx[p] = 6'd40 + RW'(p);
            e1_vld = '1; e1_idx[0] = 6'd0; e1_idx[1] = 6'd1;
            #1;
            check("R1 no ra_stall after reset", int'(ra_stall), 0);
            check("R1 no e1_stall after reset", int'(e1_stall), 0);
        end
        idle(16);
        measure(0, 1'b1, 40, 1'b0, 1'b0, 0, 0, n);
        check("R1 reset-state writer reserves nothing (lat 0)", n, 0);
    endtask

    task automatic t_int_reader();
        int n;
        put_writer(0, 5, 1'b0, 3, 6);
        measure(0, 1'b1, 5, 1'b0, 1'b0, 0, 0, n);
        check("R2 integer reader stall length", n, 3);
        idle(16);
    endtask

    task automatic t_fp_reader();
        int n;
        put_writer(0, 5, 1'b0, 3, 6);
        measure(1, 1'b1, 5, 1'b0, 1'b0, 0, 0, n);
        check("R3 fp reader stall length", n, 6);
        idle(16);
    endtask

    task automatic t_zero_count();
        int n;
        put_writer(1, 12, 1'b0, 0, 2);
        measure(0, 1'b1, 12, 1'b0, 1'b0, 0, 0, n);
        check("R4 zero integer count reserves nothing", n, 0);
        idle(16);
    endtask

    task automatic t_countdown();
        int n;
        put_writer(0, 3, 1'b0, 4, 0);
        idle(2);
        measure(0, 1'b1, 3, 1'b0, 1'b0, 0, 0, n);
        check("R5 reader two cycles late waits count-2", n, 2);
        idle(16);
    endtask

    task automatic t_double_dest();
        int n;
        put_writer(0, 8, 1'b1, 3, 0);
        measure(0, 1'b1, 9, 1'b0, 1'b0, 0, 0, n);
        check("R6 double destination reserves rd+1", n, 3);
        idle(16);
        put_writer(0, 63, 1'b1, 3, 0);
        measure(0, 1'b1, 0, 1'b0, 1'b0, 0, 0, n);
        check("R6 r63 pair does not wrap onto r0", n, 0);
        measure(0, 1'b1, 63, 1'b0, 1'b0, 0, 0, n);
        check("R6 r63 itself still reserved", n, 2);
        idle(16);
    endtask

    task automatic t_double_src();
        int n;
        put_writer(1, 11, 1'b0, 0, 4);
        measure(1, 1'b1, 10, 1'b1, 1'b0, 0, 0, n);
        check("R7 double source sees rs+1 busy", n, 4);
        idle(16);
    endtask

    task automatic t_waw();
        int n;
        put_writer(0, 20, 1'b0, 1, 4);
        measure(0, 1'b0, 0, 1'b0, 1'b1, 20, 2, n);
        check("R8 write-after-write waits for both counts", n, 4);
        measure(0, 1'b1, 20, 1'b0, 1'b0, 0, 0, n);
        check("R8 second writer reservation after advancing", n, 2);
        idle(16);
    endtask

    task automatic t_late_read();
        put_writer(0, 7, 1'b0, 4, 0);
        @(negedge clk);
        clear_all();
        e1_vld = 2'b11; e1_idx[0] = 6'd7; e1_idx[1] = 6'd7;
        #1;
        check("R9 pipe0 late read stalls", int'(e1_stall[0]), 1);
        check("R9 pipe1 late read uses fp class", int'(e1_stall[1]), 0);
        check("R9 late hazard leaves ra_stall low", int'(ra_stall), 0);
        @(negedge clk);
        clear_all();
        e1_vld[0] = 1'b1; e1_idx[0] = 6'd6; e1_dbl[0] = 1'b1;
        #1;
        check("R9 double late read sees rd+1", int'(e1_stall[0]), 1);
        idle(16);
    endtask

    task automatic t_pair();
        int n;
        int bad;
        put_writer(1, 30, 1'b0, 0, 3);
        @(negedge clk);
        clear_all();
        ra_vld = 2'b11;
        ra_dst_vld[0] = 1'b1; ra_dst_idx[0] = 6'd40; ra_lat_int[0] = 4'd5;
        ra_src_vld[1][0] = 1'b1; ra_src_idx[1][0] = 6'd30;
        e1_vld[0] = 1'b1; e1_idx[0] = 6'd40;
        #1;
        n = 0;
        bad = 0;
        while (ra_stall && n < 40) begin
            n++;
            if (e1_stall[0]) bad++;
            @(negedge clk);
            #1;
        end
        check("R10 pair held by other pipe's hazard", n, 3);
        check("R10 stalled writer reserved nothing", bad, 0);
        measure(0, 1'b1, 40, 1'b0, 1'b0, 0, 0, n);
        check("R10 writer reserves once pair advances", n, 5);
        idle(16);
    endtask

    task automatic t_ignored_fields();
        put_writer(0, 50, 1'b0, 6, 6);
        @(negedge clk);
        clear_all();
        ra_src_vld = '1; ra_src_idx[0][0] = 6'd50; ra_src_idx[1][0] = 6'd50;
        e1_idx[0] = 6'd50; e1_idx[1] = 6'd50;
        #1;
        check("R11 empty check point does not stall", int'(ra_stall), 0);
        check("R11 empty late check does not stall", int'(e1_stall), 0);
        @(negedge clk);
        clear_all();
        ra_vld[0] = 1'b1; ra_src_idx[0][1] = 6'd50;
        #1;
        check("R11 invalid source slot ignored", int'(ra_stall), 0);
        idle(16);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        clear_all();
        repeat (3) @(negedge clk);
        #1;
        t_reset_pre: begin
            checks++;
            if (ra_stall !== 1'b0 || e1_stall !== 2'b00) begin
                errors++;
                $display("FAIL R1 outputs during reset: actual %0d expected 0",
                         int'({ra_stall, e1_stall}));
            end
        end
        rst_n = 1'b1;
        t_reset();
        t_int_reader();
        t_fp_reader();
        t_zero_count();
        t_countdown();
        t_double_dest();
        t_double_src();
        t_waw();
        t_late_read();
        t_pair();
        t_ignored_fields();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule